// File: doc/BRIEF.md
# Strap-Latched Clock Output Controller

This block sits between the clock sources of a clock generator and its output pins. Four of those pins are shared. While power-on reset is active they are read as configuration straps. Three of them form a frequency-select code and the fourth picks the bus clock mode. Once reset ends, the same pins carry clocks.

The block then decides, for each of six output groups, what that group does. A group either drives its running clock, is parked low by a stop or power-down request, or is released to high impedance. The six groups are CPU, SDRAM, bus, reference, 48 MHz and 24 MHz. Each group has a clock gate that switches only while its clock is low, so no shortened pulse reaches an output.

Two reserved select codes change the whole block. One tri-states every output. The other is a production test mode that routes divided copies of the reference clock to the outputs.

Top module: `strap_clkctl`

## Requirements
- R1: While `por` is high, `out_en` is all zeros and `cfg` takes the value of `strap_i` on each rising edge of `ref_clk`. In `strap_i` and `cfg`, bits [2:0] are the select code and bit 3 is the bus mode.
- R2: After `por` falls, a change on `strap_i` has no effect on `cfg`.
- R3: `out_en` stays zero until the first rising edge of `ref_clk` after `por` falls, which is one cycle after the last strap capture. At that edge `out_en` is released.
- R4: With select code 111, `out_en` stays all zeros. Otherwise all six bits are set once released. The bit order is [0] CPU, [1] SDRAM, [2] bus, [3] reference, [4] 48 MHz, [5] 24 MHz.
- R5: With any select code other than 110 or 111, each output follows its own source: `cpu_src`, `sdram_src`, `ref_clk`, `clk48_src` and `clk24_src`.
- R6: With bus mode 1, `bus_clk` runs at half the CPU source frequency. With bus mode 0, `bus_clk` follows `bus_async_src`.
- R7: With select code 110 (test mode), the outputs run from the reference clock, each at 50% duty:
  - `ref_out` runs at REF.
  - `clk48_out`, `cpu_clk` and `sdram_clk` run at REF/2.
  - `clk24_out` runs at REF/4.
  - `bus_clk` runs at REF/4 with bus mode 1, and follows `bus_async_src` with bus mode 0.
- R8: With `pwr_dn_n` high and `cpu_stop_n` low, `cpu_clk` stops low and every other group keeps running.
- R9: With `pwr_dn_n` low, all six clock outputs stop low, whatever the level of `cpu_stop_n`.
- R10: Stopping and restarting `cpu_clk` never produces a high or low phase shorter than the half period of its selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also the strap sampling clock |
| cpu_src | input | 1 | CPU clock source |
| sdram_src | input | 1 | SDRAM clock source |
| bus_async_src | input | 1 | Fixed asynchronous bus clock source |
| clk48_src | input | 1 | 48 MHz source |
| clk24_src | input | 1 | 24 MHz source |
| por | input | 1 | Power-on reset, active high |
| strap_i | input | 4 | Level on the shared pins: [2:0] select code, [3] bus mode |
| cpu_stop_n | input | 1 | CPU stop request, active low; an open pin reads high (running) |
| pwr_dn_n | input | 1 | Power-down request, active low; an open pin reads high (running) |
| cpu_clk | output | 1 | Gated CPU clock |
| sdram_clk | output | 1 | Gated SDRAM clock |
| bus_clk | output | 1 | Gated bus clock |
| ref_out | output | 1 | Gated reference clock |
| clk48_out | output | 1 | Gated 48 MHz clock |
| clk24_out | output | 1 | Gated 24 MHz clock |
| out_en | output | 6 | Per-group pad output enable; 0 means high impedance |
| cfg | output | 4 | Latched strap configuration |

## Verification
The assertions assume that:
- `por` starts high at time zero and stays high for several reference edges;
- `strap_i` settles before the last reference edge of reset;
- the source clocks are free-running and never change while the source multiplexer is switched, so the select code changes only under reset.

The stimulus sweeps all sixteen strap values, and each one is applied through a fresh reset. The stop and power-down inputs change only well away from reset. Each change is held for hundreds of nanoseconds so the two-flop synchronisers settle before edges are counted.

// File: rtl/strap_clkctl.sv
module strap_clkctl (
  input  logic       ref_clk,
  input  logic       cpu_src,
  input  logic       sdram_src,
  input  logic       bus_async_src,
  input  logic       clk48_src,
  input  logic       clk24_src,
  input  logic       por,
  input  logic [3:0] strap_i,
  input  logic       cpu_stop_n,
  input  logic       pwr_dn_n,
  output logic       cpu_clk,
  output logic       sdram_clk,
  output logic       bus_clk,
  output logic       ref_out,
  output logic       clk48_out,
  output logic       clk24_out,
  output logic [5:0] out_en,
  output logic [3:0] cfg
);
  localparam int NG = 6;

  logic       rdy;
  logic [1:0] div;
  logic       half_q;
  logic [NG-1:0] src, req, gclk;

  always_ff @(posedge ref_clk)
    if (por) cfg <= strap_i;

  always_ff @(posedge ref_clk or posedge por)
    if (por) begin
      rdy <= 1'b0;
      div <= 2'd0;
    end else begin
      rdy <= 1'b1;
      div <= div + 2'd1;
    end

  always_ff @(posedge cpu_src or posedge por)
    if (por) half_q <= 1'b0;
    else     half_q <= ~half_q;

  wire test_m = (cfg[2:0] == 3'b110);
  wire hiz    = (cfg[2:0] == 3'b111);
  wire bus_sy = test_m ? div[1] : half_q;

  assign src[0] = test_m ? div[0] : cpu_src;
  assign src[1] = test_m ? div[0] : sdram_src;
  assign src[2] = cfg[3] ? bus_sy : bus_async_src;
  assign src[3] = ref_clk;
  assign src[4] = test_m ? div[0] : clk48_src;
  assign src[5] = test_m ? div[1] : clk24_src;

  assign req = {{(NG-1){pwr_dn_n}}, cpu_stop_n & pwr_dn_n};

  for (genvar g = 0; g < NG; g++) begin : g_gate
    logic [1:0] sy;
    logic       en;
    always_ff @(posedge src[g] or posedge por)
      if (por) sy <= 2'b00;
      else     sy <= {sy[0], req[g]};
    always_ff @(negedge src[g] or posedge por)
      if (por) en <= 1'b0;
      else     en <= sy[1];
    assign gclk[g] = src[g] & en;

    // R8 R9: a withdrawn request parks the group low by the next falling edge
    a_r8_group_parks: assert property (@(negedge src[g]) disable iff (por)
      !sy[1] |=> !gclk[g]);
  end

  assign {clk24_out, clk48_out, ref_out, bus_clk, sdram_clk, cpu_clk} = gclk;
  assign out_en = {NG{rdy & ~hiz}};

  a_r1_hiz_in_reset: assert property (@(posedge ref_clk)
    por |-> out_en == 6'b0);

  a_r2_straps_hold: assert property (@(posedge ref_clk) disable iff (por)
    !$past(por) |-> $stable(cfg));

  a_r3_first_edge_quiet: assert property (@(posedge ref_clk) disable iff (por)
    $past(por) |-> out_en == 6'b0);

  a_r3_release: assert property (@(posedge ref_clk) disable iff (por)
    (!$past(por) && $past(por, 2)) |-> (out_en == {NG{cfg[2:0] != 3'b111}}));

  a_r4_tristate: assert property (@(posedge ref_clk) disable iff (por)
    (cfg[2:0] == 3'b111) |-> out_en == 6'b0);
endmodule

// File: tb/strap_clkctl_tb.sv
`timescale 1ns/1ps
module strap_clkctl_tb;
  logic ref_clk = 0, cpu_src = 0, sdram_src = 0, bus_async_src = 0, clk48_src = 0, clk24_src = 0;
  logic por = 1;
  logic [3:0] strap_i = 0;
  logic cpu_stop_n = 1, pwr_dn_n = 1;
  logic cpu_clk, sdram_clk, bus_clk, ref_out, clk48_out, clk24_out;
  logic [5:0] out_en;
  logic [3:0] cfg;

  strap_clkctl u_dut (.*);

  always #10 ref_clk = ~ref_clk;
  always #7  cpu_src = ~cpu_src;
  always #8  sdram_src = ~sdram_src;
  always #15 bus_async_src = ~bus_async_src;
  always #11 clk48_src = ~clk48_src;
  always #21 clk24_src = ~clk24_src;

  int compared = 0, mismatched = 0;
  localparam real W = 2000.0;
  logic win = 0;
  int cnt [6];
  wire [5:0] outs = {clk24_out, clk48_out, ref_out, bus_clk, sdram_clk, cpu_clk};

  always @(posedge cpu_clk)   if (win) cnt[0]++;
  always @(posedge sdram_clk) if (win) cnt[1]++;
  always @(posedge bus_clk)   if (win) cnt[2]++;
  always @(posedge ref_out)   if (win) cnt[3]++;
  always @(posedge clk48_out) if (win) cnt[4]++;
  always @(posedge clk24_out) if (win) cnt[5]++;

  real trise = -1.0, tfall = -1.0, minhi = 1.0e9, minlo = 1.0e9;
  logic pw_on = 0;
  always @(posedge cpu_clk) begin
    if (pw_on && tfall >= 0.0 && ($realtime - tfall) < minlo) minlo = $realtime - tfall;
    trise = $realtime;
  end
  always @(negedge cpu_clk) begin
    if (pw_on && trise >= 0.0 && ($realtime - trise) < minhi) minhi = $realtime - trise;
    tfall = $realtime;
  end

  task automatic check(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_rate(string tag, int got, real per);
    int e;
    e = $rtoi(W / per);
    compared++;
    if (got < e - 1 || got > e + 1) begin
      mismatched++;
      $display("FAIL %s: got %0d edges expected %0d", tag, got, e);
    end
  endtask

  task automatic measure();
    for (int i = 0; i < 6; i++) cnt[i] = 0;
    win = 1;
    #(W);
    win = 0;
    #0.5;
  endtask

  function automatic real period(int g, logic [2:0] code, logic bm);
    logic t;
    t = (code == 3'b110);
    case (g)
      0: return t ? 40.0 : 14.0;
      1: return t ? 40.0 : 16.0;
      2: return bm ? (t ? 80.0 : 28.0) : 30.0;
      3: return 20.0;
      4: return t ? 40.0 : 22.0;
      default: return t ? 80.0 : 42.0;
    endcase
  endfunction

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      logic [3:0] st;
      logic [2:0] code;
      logic bm;
      real half;
      st = s[3:0];
      code = st[2:0];
      bm = st[3];
      cpu_stop_n = 1; pwr_dn_n = 1;
      strap_i = st;
      por = 1;
      repeat (4) @(posedge ref_clk);
      #1 check("R1 out_en in reset", int'(out_en), 0);
      @(negedge ref_clk);
      por = 0;
      #1;
      check("R1 cfg latched", int'(cfg), int'(st));
      check("R3 out_en before first edge", int'(out_en), 0);
      @(posedge ref_clk);
      #1 check("R3 R4 out_en released", int'(out_en), (code == 3'b111) ? 0 : 63);
      strap_i = ~st;
      repeat (3) @(posedge ref_clk);
      #1 check("R2 straps ignored", int'(cfg), int'(st));
      if (code == 3'b111) begin
        #500 check("R4 tristate holds", int'(out_en), 0);
        continue;
      end
      #400;
      measure();
      for (int g = 0; g < 6; g++)
        chk_rate($sformatf("R5 R6 R7 group %0d cfg %0d", g, s), cnt[g], period(g, code, bm));

      half = period(0, code, bm) / 2.0;
      minhi = 1.0e9; minlo = 1.0e9; trise = -1.0; tfall = -1.0; pw_on = 1;
      cpu_stop_n = 0;
      #400;
      measure();
      check("R8 cpu stopped", cnt[0], 0);
      check("R8 cpu parked low", int'(cpu_clk), 0);
      for (int g = 1; g < 6; g++)
        chk_rate($sformatf("R8 group %0d runs", g), cnt[g], period(g, code, bm));
      cpu_stop_n = 1;
      #400;
      measure();
      chk_rate("R8 cpu restarts", cnt[0], period(0, code, bm));
      pw_on = 0;
      check("R10 min high phase ok", (minhi >= half - 0.1) ? 1 : 0, 1);
      check("R10 min low phase ok", (minlo >= half - 0.1) ? 1 : 0, 1);

      pwr_dn_n = 0;
      #400;
      measure();
      for (int g = 0; g < 6; g++)
        check($sformatf("R9 group %0d stopped", g), cnt[g], 0);
      check("R9 all parked low", int'(outs), 0);
      pwr_dn_n = 1;
      #400;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule